// File: doc/BRIEF.md
# Byte Shift and Rotate Unit

This unit is the shift and rotate path of a small processor's execute stage. It is purely combinational. It takes an operand byte, the current carry flag and a 3-bit operation code. In the same cycle it returns the shifted or rotated result and new values for the carry, zero, negative, overflow and sign flags. Each flag comes with a write strobe, so the status register keeps any flag that the operation does not touch.

The unit provides these operations:

- a logical shift in either direction;
- a rotate through carry in either direction;
- an arithmetic right shift that keeps the sign bit;
- a nibble swap that leaves every flag alone.

The two unused operation codes pass the operand through and write no flags. The operand width is a parameter with a default of 8, and it must be even.

Top module: `sro_unit`

## Requirements
- R1: Operation code 0 (shift left) gives a result equal to the operand doubled modulo 2^W, with 0 entering bit 0. The carry value (flag bit 0) is the old operand MSB.
- R2: Operation code 1 (shift right) gives the operand halved, with 0 entering the MSB. The carry value is the old operand bit 0.
- R3: Operation code 2 (rotate left through carry) puts the old carry input into bit 0 and shifts the other bits up. The carry value is the old operand MSB.
- R4: Operation code 3 (rotate right through carry) puts the old carry input into the MSB and shifts the other bits down. The carry value is the old operand bit 0.
- R5: Operation code 4 (arithmetic shift right) moves bits W-1..1 into bits W-2..0 and keeps the MSB. The carry value is the old operand bit 0.
- R6: Operation code 5 (swap) exchanges the upper and lower halves of the operand. All five write strobes are 0.
- R7: For operation codes 0 to 4, the negative flag (flag bit 2) equals the result MSB. The zero flag (flag bit 1) is 1 exactly when the result is zero.
- R8: For operation codes 0 to 4, the overflow flag (flag bit 3) equals negative XOR carry. The sign flag (flag bit 4) equals negative XOR overflow.
- R9: For operation codes 0 to 4, all five write strobes (same bit order as the flags) are 1.
- R10: Operation codes 6 and 7 return the operand unchanged and raise no write strobe.
- R11: A flag value output whose write strobe is 0 reads as 0.
- R12: The outputs follow the inputs within the same cycle, with no register between them. With all inputs at zero, the result is 0 and the flag outputs are 5'b00010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (0 shift left, 1 shift right, 2 rotate left, 3 rotate right, 4 arithmetic shift right, 5 swap, 6 and 7 pass-through) |
| opnd_i | input | W | Operand |
| cin_i | input | 1 | Current carry flag |
| res_o | output | W | Result |
| flag_o | output | 5 | New flag values: [0] carry, [1] zero, [2] negative, [3] overflow, [4] sign |
| flag_we_o | output | 5 | Write strobe per flag, same bit order as flag_o |

## Verification
The hardest cases involve the carry input and the MSB fill. A rotate must move the incoming carry into the result, and an arithmetic shift of a negative operand must copy the sign bit back in. Both can hide an error that a sweep with the carry held at one value would never show. The bench therefore sweeps every operation code against every operand with both carry values, 4096 combinations in all. That sweep also covers the zero results that set the zero flag and the cases where overflow and sign differ.

// File: rtl/sro_pkg.sv
package sro_pkg;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_ROL  = 3'd2,
        OP_ROR  = 3'd3,
        OP_ASR  = 3'd4,
        OP_SWAP = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } sro_op_e;

    localparam int NFLAG = 5;
    localparam int FC    = 0;
    localparam int FZ    = 1;
    localparam int FN    = 2;
    localparam int FV    = 3;
    localparam int FS    = 4;

    typedef struct packed {
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sro_flags_t;

    // Shifts and rotates take the whole arithmetic flag set.
    function automatic logic op_writes_flags(sro_op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) ||
               (op == OP_ROR) || (op == OP_ASR);
    endfunction

    function automatic logic op_moves_left(sro_op_e op);
        return (op == OP_SHL) || (op == OP_ROL);
    endfunction

    function automatic logic op_moves_right(sro_op_e op);
        return (op == OP_SHR) || (op == OP_ROR) || (op == OP_ASR);
    endfunction

endpackage

// File: rtl/sro_shift_core.sv
module sro_shift_core
    import sro_pkg::*;
#(
    parameter int W = 8
) (
    input  sro_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam int H = W / 2;

    logic         fill_lo;
    logic         fill_hi;
    logic [W-1:0] up_q;
    logic [W-1:0] dn_q;
    logic [W-1:0] sw_q;

    assign fill_lo = (op == OP_ROL) & cin;

    always_comb begin
        case (op)
            OP_ROR:  fill_hi = cin;
            OP_ASR:  fill_hi = a[W-1];
            default: fill_hi = 1'b0;
        endcase
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lo_edge
            assign up_q[i] = fill_lo;
        end else begin : g_lo_mid
            assign up_q[i] = a[i-1];
        end
        if (i == W - 1) begin : g_hi_edge
            assign dn_q[i] = fill_hi;
        end else begin : g_hi_mid
            assign dn_q[i] = a[i+1];
        end
        assign sw_q[i] = a[(i + H) % W];
    end

    always_comb begin
        if (op_moves_left(op)) begin
            res  = up_q;
            cout = a[W-1];
        end else if (op_moves_right(op)) begin
            res  = dn_q;
            cout = a[0];
        end else if (op == OP_SWAP) begin
            res  = sw_q;
            cout = 1'b0;
        end else begin
            res  = a;
            cout = 1'b0;
        end
    end

    always_comb begin
        if (op == OP_ROL) begin
            a_r3_rol_carry_in : assert (res[0] == cin);
        end
        if (op == OP_ROR) begin
            a_r4_ror_carry_in : assert (res[W-1] == cin);
        end
        if (op == OP_ASR) begin
            a_r5_asr_keeps_msb : assert (res[W-1] == a[W-1]);
        end
    end

endmodule

// File: rtl/sro_flag_gen.sv
module sro_flag_gen
    import sro_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] res,
    input  logic         cout,
    output sro_flags_t   flags
);
    always_comb begin
        flags.c = cout;
        flags.n = res[W-1];
        flags.z = ~|res;
        flags.v = flags.n ^ flags.c;
        flags.s = flags.n ^ flags.v;
    end

endmodule

// File: rtl/sro_mask_dec.sv
module sro_mask_dec
    import sro_pkg::*;
(
    input  sro_op_e    op,
    output sro_flags_t we
);
    logic all_on;

    assign all_on = op_writes_flags(op);

    always_comb begin
        we.c = all_on;
        we.z = all_on;
        we.n = all_on;
        we.v = all_on;
        // Sign is written together with overflow.
        we.s = we.v;
    end

endmodule

// File: rtl/sro_unit.sv
module sro_unit
    import sro_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]       op_i,
    input  logic [W-1:0]     opnd_i,
    input  logic             cin_i,
    output logic [W-1:0]     res_o,
    output logic [NFLAG-1:0] flag_o,
    output logic [NFLAG-1:0] flag_we_o
);
    sro_op_e      op;
    logic [W-1:0] res_w;
    logic         cout_w;
    sro_flags_t   raw_flags;
    sro_flags_t   we_w;

    assign op = sro_op_e'(op_i);

    sro_shift_core #(.W(W)) u_core (
        .op   (op),
        .a    (opnd_i),
        .cin  (cin_i),
        .res  (res_w),
        .cout (cout_w)
    );

    sro_flag_gen #(.W(W)) u_flags (
        .res   (res_w),
        .cout  (cout_w),
        .flags (raw_flags)
    );

    sro_mask_dec u_mask (
        .op (op),
        .we (we_w)
    );

    assign res_o     = res_w;
    assign flag_we_o = we_w;
    assign flag_o    = raw_flags & we_w;

    always_comb begin
        if (op == OP_SWAP) begin
            a_r6_swap_no_flags : assert (flag_we_o == '0);
        end
        if (flag_we_o[FZ]) begin
            a_r7_zero_matches : assert (flag_o[FZ] == (res_o == '0));
        end
        if (flag_we_o[FV]) begin
            a_r8_overflow_rule : assert (flag_o[FV] == (flag_o[FN] ^ flag_o[FC]));
            a_r8_sign_rule : assert (flag_o[FS] == (flag_o[FN] ^ flag_o[FV]));
        end
        a_r11_masked_zero : assert ((flag_o & ~flag_we_o) == '0);
        if (op_i[2:1] == 2'b11) begin
            a_r10_pass_through : assert (res_o == opnd_i);
        end
    end

endmodule

// File: tb/sro_unit_tb.sv
module sro_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = '0;
    logic [7:0] opnd_i = '0;
    logic       cin_i = 1'b0;
    logic [7:0] res_o;
    logic [4:0] flag_o;
    logic [4:0] flag_we_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sro_unit #(.W(8)) u_dut (
        .op_i      (op_i),
        .opnd_i    (opnd_i),
        .cin_i     (cin_i),
        .res_o     (res_o),
        .flag_o    (flag_o),
        .flag_we_o (flag_we_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h cin=%0d actual=%0h expected=%0h",
                     tag, op_i, opnd_i, cin_i, act, exp);
        end
    endtask

    function automatic string res_tag(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R12: reset state, all inputs zero
        @(negedge clk);
        #1;
        chk("R12", res_o, 0);
        chk("R12", flag_o, 5'b00010);
        rst = 1'b0;

        // R12: output follows input without a clock edge
        @(negedge clk);
        op_i = 3'd0; opnd_i = 8'h81; cin_i = 1'b0;
        #1;
        chk("R12", res_o, 8'h02);

        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 2; c++) begin
                    int er, ec, en, ez, ev, es, ew, ef;
                    @(negedge clk);
                    op_i = 3'(op); opnd_i = 8'(a); cin_i = c[0];
                    #2;
                    ec = 0;
                    case (op)
                        0: begin er = (a * 2) % 256;           ec = a / 128; end
                        1: begin er = a / 2;                   ec = a % 2;   end
                        2: begin er = (a * 2) % 256 + c;       ec = a / 128; end
                        3: begin er = a / 2 + c * 128;         ec = a % 2;   end
                        4: begin er = a / 2 + (a / 128) * 128; ec = a % 2;   end
                        5: begin er = (a % 16) * 16 + a / 16;             end
                        default: er = a;
                    endcase
                    chk(res_tag(op), res_o, er);
                    if (op < 5) begin
                        en = er / 128;
                        ez = (er == 0) ? 1 : 0;
                        ev = en ^ ec;
                        es = en ^ ev;
                        ef = es * 16 + ev * 8 + en * 4 + ez * 2 + ec;
                        ew = 31;
                        chk("R7/R8", flag_o, ef);
                        chk("R9", flag_we_o, ew);
                    end else begin
                        chk("R11", flag_o, 0);
                        chk((op == 5) ? "R6" : "R10", flag_we_o, 0);
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule